// File: doc/BRIEF.md
# Bit-Serial HDLC Frame Transmitter with Graceful Pause

This block turns whole packets, read one byte at a time from an external transmit queue, into an HDLC bit stream. Each packet goes out as an opening flag octet (0x7E), its bytes least significant bit first with a zero inserted after every run of five ones, and a closing flag octet. The line advances by one bit on each cycle in which the bit strobe is high. Between frames the line carries either back-to-back flag octets or a steady high level, depending on a fill-select input.

A pause input stops transmission without breaking a frame. A frame already started runs to completion, and the next queued packet stays in the queue untouched. An acknowledge output reports that the pause has taken hold. It rises one cycle after pause is raised if no packet is in flight, or otherwise in the cycle after the last byte of the current packet has been taken from the queue. Lowering pause drops the acknowledge and lets the queued packet start at the next frame boundary.

Top module: `hdlc_tx_engine`

## Requirements
- R1: After reset, `tx_bit` is 1, `fifo_pop` is 0 and `pause_done` is 0.
- R2: Each packet is sent as the flag 0x7E, its bytes in queue order with each byte least significant bit first, then the flag 0x7E. Removing the stuffed zeros between the two flags gives back exactly the packet bytes.
- R3: Between the flags of a frame, a 0 is sent after every five consecutive 1 data bits, including a run that ends on a byte boundary or at the last byte. Flag octets are never stuffed.
- R4: With `fill_flags` = 1 and nothing to send, the line carries repeated 0x7E octets. A new frame starts only on an octet boundary of that fill.
- R5: With `fill_flags` = 0 and nothing to send, `tx_bit` stays 1 on every strobe.
- R6: `fifo_pop` is raised only while `fifo_valid` is 1, and it takes one byte per pop. A frame starts only when the head byte carries `fifo_sop` = 1.
- R7: Raising `pause_req` during a frame does not shorten it: that frame completes with its closing flag.
- R8: While `pause_req` is 1, no byte of any later packet is popped and no new frame starts.
- R9: If `pause_req` is raised while no packet is in flight, `pause_done` is 1 in the following cycle.
- R10: If a packet is in flight, `pause_done` stays 0 until the byte marked `fifo_eop` is popped and becomes 1 in the cycle after that pop.
- R11: When `pause_req` falls, `pause_done` is 0 in the next cycle, and the queued packet is then sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit strobe: one line bit per high cycle |
| fill_flags | input | 1 | Idle fill select: 1 = flag octets, 0 = steady ones |
| pause_req | input | 1 | Pause command (level) |
| fifo_valid | input | 1 | Queue head byte present |
| fifo_data | input | 8 | Queue head byte |
| fifo_sop | input | 1 | Head byte is the first byte of a packet |
| fifo_eop | input | 1 | Head byte is the last byte of a packet |
| fifo_pop | output | 1 | Take the head byte this cycle |
| tx_bit | output | 1 | Serial line output |
| pause_done | output | 1 | Pause has taken effect |

## Verification
The bench decodes the line independently, finding flags, removing stuffed zeros and rebuilding frames, and scores them against the packets it queued. Bytes 0xFF, 0x7E and 0xF8 place runs of five ones mid-byte, across bytes and right before the closing flag. A stuffer that misses any of these yields a wrong byte, a bit count that is not a multiple of eight, or a false flag. The pause tests raise pause both with the line idle and right after the first byte of a five-byte packet. On every cycle they compare the acknowledge against the bench's own count of popped bytes, so an acknowledge that rises early, or one that waits for the closing flag, is reported. A transmitter that cuts the frame or takes the next packet's first byte while paused shows up as a missing frame or a moved read pointer.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  localparam int OCTET_W = 8;
  localparam int CNT_W   = $clog2(OCTET_W);
  localparam logic [OCTET_W-1:0] FLAG_OCTET = 8'h7E;

  typedef enum logic [1:0] {
    ST_FILL  = 2'd0,
    ST_OPEN  = 2'd1,
    ST_BODY  = 2'd2,
    ST_CLOSE = 2'd3
  } tx_state_e;

  // Bit of the flag octet sent at position idx (LSB leaves first)
  function automatic logic flag_bit(input logic [CNT_W-1:0] idx);
    return FLAG_OCTET[idx];
  endfunction

  // Length of the run of ones after one more data bit
  function automatic int run_next(input int run, input logic b);
    return b ? run + 1 : 0;
  endfunction

  // Last bit position of an octet
  function automatic logic octet_last(input logic [CNT_W-1:0] idx);
    return idx == CNT_W'(OCTET_W - 1);
  endfunction

endpackage

// File: rtl/hdlc_tx_stuffer.sv
module hdlc_tx_stuffer
  import hdlc_tx_pkg::*;
#(
  parameter int STUFF_RUN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  input  logic bit_in,
  input  logic stuff_taken,
  output logic stuff_due
);

  localparam int RUN_W = $clog2(STUFF_RUN + 1);

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (clr || stuff_taken) begin
      run_q <= '0;
    end else if (adv) begin
      run_q <= RUN_W'(run_next(int'(run_q), bit_in));
    end
  end

  assign stuff_due = (run_q == RUN_W'(STUFF_RUN));

endmodule

// File: rtl/hdlc_tx_pause_ctl.sv
module hdlc_tx_pause_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic pause_req,
  input  logic in_flight,
  input  logic eop_pop,
  output logic pause_done
);

  logic done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else if (!pause_req) begin
      done_q <= 1'b0;
    end else if (!done_q) begin
      done_q <= !in_flight || eop_pop;
    end
  end

  assign pause_done = done_q;

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
  import hdlc_tx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_en,
  input  logic               fill_flags,
  input  logic               pause_req,
  input  logic               fifo_valid,
  input  logic [OCTET_W-1:0] fifo_data,
  input  logic               fifo_sop,
  input  logic               fifo_eop,
  input  logic               stuff_due,
  output logic               fifo_pop,
  output logic               tx_bit,
  output logic               data_adv,
  output logic               data_bit,
  output logic               stuff_taken,
  output logic               in_body,
  output logic               in_flight,
  output logic               eop_pop,
  output logic               idle_one
);

  tx_state_e          state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [OCTET_W-1:0] sh_q, sh_d;
  logic               eop_q, eop_d;
  logic               drained_q, drained_d;
  logic               tx_q, tx_d;
  logic               start_ok;

  assign start_ok = fifo_valid && fifo_sop && !pause_req;

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    sh_d        = sh_q;
    eop_d       = eop_q;
    drained_d   = drained_q;
    tx_d        = tx_q;
    fifo_pop    = 1'b0;
    data_adv    = 1'b0;
    data_bit    = 1'b0;
    stuff_taken = 1'b0;
    idle_one    = 1'b0;
    if (bit_en) begin
      unique case (state_q)
        ST_FILL: begin
          if (cnt_q == '0 && start_ok) begin
            tx_d    = flag_bit('0);
            cnt_d   = CNT_W'(1);
            state_d = ST_OPEN;
          end else if (fill_flags) begin
            tx_d  = flag_bit(cnt_q);
            cnt_d = cnt_q + CNT_W'(1);
          end else begin
            tx_d     = 1'b1;
            cnt_d    = '0;
            idle_one = 1'b1;
          end
        end
        ST_OPEN: begin
          tx_d = flag_bit(cnt_q);
          if (octet_last(cnt_q)) begin
            cnt_d     = '0;
            drained_d = 1'b1;
            eop_d     = 1'b0;
            state_d   = ST_BODY;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        ST_BODY: begin
          if (stuff_due) begin
            tx_d        = 1'b0;
            stuff_taken = 1'b1;
          end else if (drained_q) begin
            if (!eop_q && fifo_valid) begin
              fifo_pop  = 1'b1;
              tx_d      = fifo_data[0];
              data_adv  = 1'b1;
              data_bit  = fifo_data[0];
              sh_d      = fifo_data >> 1;
              eop_d     = fifo_eop;
              cnt_d     = CNT_W'(1);
              drained_d = 1'b0;
            end else begin
              tx_d    = flag_bit('0);
              cnt_d   = CNT_W'(1);
              state_d = ST_CLOSE;
            end
          end else begin
            tx_d     = sh_q[0];
            data_adv = 1'b1;
            data_bit = sh_q[0];
            sh_d     = sh_q >> 1;
            if (octet_last(cnt_q)) begin
              cnt_d     = '0;
              drained_d = 1'b1;
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
            end
          end
        end
        ST_CLOSE: begin
          tx_d = flag_bit(cnt_q);
          if (octet_last(cnt_q)) begin
            cnt_d   = '0;
            state_d = ST_FILL;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        default: state_d = ST_FILL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_FILL;
      cnt_q     <= '0;
      sh_q      <= '0;
      eop_q     <= 1'b0;
      drained_q <= 1'b0;
      tx_q      <= 1'b1;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      sh_q      <= sh_d;
      eop_q     <= eop_d;
      drained_q <= drained_d;
      tx_q      <= tx_d;
    end
  end

  assign tx_bit    = tx_q;
  assign in_body   = (state_q == ST_BODY);
  assign in_flight = (state_q == ST_OPEN) || (state_q == ST_BODY && !eop_q);
  assign eop_pop   = fifo_pop && fifo_eop;

endmodule

// File: rtl/hdlc_tx_engine.sv
module hdlc_tx_engine
  import hdlc_tx_pkg::*;
#(
  parameter int STUFF_RUN = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_en,
  input  logic               fill_flags,
  input  logic               pause_req,
  input  logic               fifo_valid,
  input  logic [OCTET_W-1:0] fifo_data,
  input  logic               fifo_sop,
  input  logic               fifo_eop,
  output logic               fifo_pop,
  output logic               tx_bit,
  output logic               pause_done
);

  logic data_adv;
  logic data_bit;
  logic stuff_taken;
  logic stuff_due;
  logic in_body;
  logic in_flight;
  logic eop_pop;
  logic idle_one;

  hdlc_tx_framer u_framer (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_en      (bit_en),
    .fill_flags  (fill_flags),
    .pause_req   (pause_req),
    .fifo_valid  (fifo_valid),
    .fifo_data   (fifo_data),
    .fifo_sop    (fifo_sop),
    .fifo_eop    (fifo_eop),
    .stuff_due   (stuff_due),
    .fifo_pop    (fifo_pop),
    .tx_bit      (tx_bit),
    .data_adv    (data_adv),
    .data_bit    (data_bit),
    .stuff_taken (stuff_taken),
    .in_body     (in_body),
    .in_flight   (in_flight),
    .eop_pop     (eop_pop),
    .idle_one    (idle_one)
  );

  hdlc_tx_stuffer #(
    .STUFF_RUN (STUFF_RUN)
  ) u_stuffer (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (!in_body),
    .adv         (data_adv),
    .bit_in      (data_bit),
    .stuff_taken (stuff_taken),
    .stuff_due   (stuff_due)
  );

  hdlc_tx_pause_ctl u_pause (
    .clk        (clk),
    .rst_n      (rst_n),
    .pause_req  (pause_req),
    .in_flight  (in_flight),
    .eop_pop    (eop_pop),
    .pause_done (pause_done)
  );

endmodule

// File: rtl/hdlc_tx_engine_chk.sv
module hdlc_tx_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic pause_req,
  input logic fifo_valid,
  input logic fifo_pop,
  input logic tx_bit,
  input logic pause_done,
  input logic in_flight,
  input logic stuff_due,
  input logic idle_one
);

  // R6
  pop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> fifo_valid);

  // R8
  paused_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pause_done |-> !fifo_pop);

  // R9
  idle_pause_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_req && !in_flight && !pause_done) |=> pause_done);

  // R11
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pause_req |=> !pause_done);

  // R3
  stuff_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && stuff_due) |=> !tx_bit);

  // R5
  idle_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_one |=> tx_bit);

endmodule

bind hdlc_tx_engine hdlc_tx_engine_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_en     (bit_en),
  .pause_req  (pause_req),
  .fifo_valid (fifo_valid),
  .fifo_pop   (fifo_pop),
  .tx_bit     (tx_bit),
  .pause_done (pause_done),
  .in_flight  (in_flight),
  .stuff_due  (stuff_due),
  .idle_one   (idle_one)
);

// File: tb/test_hdlc_tx_engine.sv
module test_hdlc_tx_engine;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_en = 1'b0;
  logic       fill_flags;
  logic       pause_req;
  logic       fifo_valid;
  logic [7:0] fifo_data;
  logic       fifo_sop;
  logic       fifo_eop;
  logic       fifo_pop;
  logic       tx_bit;
  logic       pause_done;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hdlc_tx_engine i_hdlc_tx_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .fill_flags (fill_flags),
    .pause_req  (pause_req),
    .fifo_valid (fifo_valid),
    .fifo_data  (fifo_data),
    .fifo_sop   (fifo_sop),
    .fifo_eop   (fifo_eop),
    .fifo_pop   (fifo_pop),
    .tx_bit     (tx_bit),
    .pause_done (pause_done)
  );

  // Queue model
  logic [7:0] mem_data [256];
  logic       mem_sop  [256];
  logic       mem_eop  [256];
  logic [7:0] wr_ptr = '0;
  logic [7:0] rd_ptr = '0;

  assign fifo_valid = (rd_ptr != wr_ptr);
  assign fifo_data  = mem_data[rd_ptr];
  assign fifo_sop   = mem_sop[rd_ptr];
  assign fifo_eop   = mem_eop[rd_ptr];

  always @(posedge clk) if (fifo_pop) rd_ptr <= rd_ptr + 8'd1;

  logic bit_en_q = 1'b0;
  always @(posedge clk) bit_en_q <= bit_en;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // Scoreboard
  int         exp_len[$];
  logic [7:0] exp_bytes[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push_pkt(input logic [7:0] d[$]);
    for (int i = 0; i < d.size(); i++) begin
      mem_data[wr_ptr] = d[i];
      mem_sop[wr_ptr]  = (i == 0);
      mem_eop[wr_ptr]  = (i == d.size() - 1);
      exp_bytes.push_back(d[i]);
      wr_ptr = wr_ptr + 8'd1;
    end
    exp_len.push_back(d.size());
  endtask

  // Monitor: line decoder
  int   ones = 0;
  bit   in_frame = 1'b0;
  bit   bitbuf[$];
  int   frames_rcvd = 0;
  int   flags_seen = 0;
  int   zeros_seen = 0;

  task automatic finish_frame();
    int nb;
    logic [7:0] got, want;
    if (bitbuf.size() % 8 != 0) begin
      chk(1'b0, "R2 frame bit count", bitbuf.size(), (bitbuf.size() / 8) * 8);
      return;
    end
    nb = bitbuf.size() / 8;
    if (exp_len.size() == 0) begin
      chk(1'b0, "R2 unexpected frame", nb, 0);
      return;
    end
    chk(nb == exp_len[0], "R2 frame length", nb, exp_len[0]);
    if (nb == exp_len[0]) begin
      for (int k = 0; k < nb; k++) begin
        for (int j = 0; j < 8; j++) got[j] = bitbuf[k * 8 + j];
        want = exp_bytes.pop_front();
        chk(got == want, "R2 R3 frame byte", got, want);
      end
    end else begin
      for (int k = 0; k < exp_len[0]; k++) void'(exp_bytes.pop_front());
    end
    void'(exp_len.pop_front());
    frames_rcvd++;
  endtask

  always @(negedge clk) begin
    if (rst_n && bit_en_q) begin
      if (tx_bit) begin
        ones++;
        bitbuf.push_back(1'b1);
        if (ones >= 7) begin
          in_frame = 1'b0;
          bitbuf.delete();
        end
      end else begin
        zeros_seen++;
        if (ones == 5) begin
          // stuffed zero, dropped
        end else if (ones == 6) begin
          flags_seen++;
          if (bitbuf.size() >= 7) begin
            repeat (7) void'(bitbuf.pop_back());
          end else begin
            bitbuf.delete();
          end
          if (in_frame && bitbuf.size() > 0) finish_frame();
          bitbuf.delete();
          in_frame = 1'b1;
        end else begin
          bitbuf.push_back(1'b0);
        end
        ones = 0;
      end
    end
  end

  // Strobe generator
  bit strobe_on = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      bit_en = strobe_on ? ~bit_en : 1'b0;
    end
  end

  task automatic wait_strobes(input int n);
    repeat (2 * n) @(negedge clk);
  endtask

  task automatic wait_frames(input int target, input string req);
    for (int i = 0; i < 6000 && frames_rcvd < target; i++) @(negedge clk);
    chk(frames_rcvd >= target, req, frames_rcvd, target);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] pk[$];
    int base, f0, z0;
    logic [7:0] p1_first, r0, popped;
    bit bad;
    rst_n = 1'b0;
    fill_flags = 1'b1;
    pause_req = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(tx_bit == 1'b1, "R1 tx_bit", tx_bit, 1);
    chk(fifo_pop == 1'b0, "R1 fifo_pop", fifo_pop, 0);
    chk(pause_done == 1'b0, "R1 pause_done", pause_done, 0);
    strobe_on = 1'b1;

    // R4 flag fill
    wait_strobes(8);
    f0 = flags_seen;
    wait_strobes(40);
    chk(flags_seen - f0 >= 4, "R4 flags in fill", flags_seen - f0, 5);

    // R2 R3 packet in flag fill, runs of ones mid-byte, across bytes, at end
    pk = '{8'h12, 8'h7E, 8'hFF, 8'h1F, 8'hF8};
    push_pkt(pk);
    wait_frames(1, "R2 R3 frame in flag fill");

    // R5 idle ones
    fill_flags = 1'b0;
    wait_strobes(20);
    z0 = zeros_seen;
    wait_strobes(30);
    chk(zeros_seen == z0, "R5 zeros in idle fill", zeros_seen - z0, 0);

    // R2 packet with idle fill
    pk = '{8'hA5, 8'h00, 8'h3C};
    push_pkt(pk);
    wait_frames(2, "R2 frame in idle fill");

    // R9 pause while idle
    wait_strobes(10);
    pause_req = 1'b1;
    @(negedge clk);
    chk(pause_done == 1'b1, "R9 immediate ack", pause_done, 1);
    pk = '{8'h55, 8'hC3};
    push_pkt(pk);
    r0 = rd_ptr;
    wait_strobes(60);
    chk(rd_ptr == r0, "R8 no pop while paused", rd_ptr, r0);
    chk(frames_rcvd == 2, "R8 no frame while paused", frames_rcvd, 2);
    pause_req = 1'b0;
    @(negedge clk);
    chk(pause_done == 1'b0, "R11 ack clears", pause_done, 0);
    wait_frames(3, "R11 resume sends queued packet");

    // R10 R7 pause during a frame
    fill_flags = 1'b1;
    wait_strobes(12);
    base = frames_rcvd;
    p1_first = wr_ptr;
    pk = '{8'h81, 8'hFF, 8'h7E, 8'h3F, 8'hE7};
    push_pkt(pk);
    pk = '{8'h0F, 8'hBE};
    push_pkt(pk);
    for (int i = 0; i < 2000 && rd_ptr == p1_first; i++) @(negedge clk);
    pause_req = 1'b1;
    bad = 1'b0;
    for (int i = 0; i < 4000 && !pause_done; i++) begin
      @(negedge clk);
      popped = rd_ptr - p1_first;
      if (pause_done != (popped >= 8'd5)) bad = 1'b1;
    end
    popped = rd_ptr - p1_first;
    chk(!bad, "R10 ack tracks eop pop", bad, 0);
    chk(pause_done && popped == 8'd5, "R10 ack after eop", popped, 5);
    wait_frames(base + 1, "R7 paused frame completes");
    wait_strobes(60);
    popped = rd_ptr - p1_first;
    chk(popped == 8'd5, "R8 next packet held", popped, 5);
    chk(frames_rcvd == base + 1, "R8 no frame while paused", frames_rcvd, base + 1);
    pause_req = 1'b0;
    @(negedge clk);
    chk(pause_done == 1'b0, "R11 ack clears", pause_done, 0);
    wait_frames(base + 2, "R11 queued packet sent");

    wait_strobes(20);
    chk(exp_len.size() == 0, "R2 scoreboard drained", exp_len.size(), 0);
    chk(rd_ptr == wr_ptr, "R6 all bytes popped once", rd_ptr, wr_ptr);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule